// File: doc/BRIEF.md
# Two-Channel Converter Drive Pulse Generator

This block produces two fixed-rate switch drive waveforms for external DC-to-DC converters. A shared slot counter divides each frame into sixteen slots. It advances once per strobe on the `tick` input, which is asserted sixteen times per 96 kHz frame (1.536 MHz). Each channel drives its output active for the first N slots of every frame. N is a duty code from 1 to 15, so the output never stays fully on or fully off.

Each channel has an enable, a duty code and a polarity select. Positive polarity suits a buck-style converter (active high). Negative polarity suits an inverting converter (active low). Duty, polarity and enable-on are taken into use only at a frame boundary, so a change never produces a runt pulse.

A feedback input per channel, for example from a comparator, cuts the pulse short. It passes through a two-flop synchroniser. Once asserted, it holds the channel inactive for the rest of the frame.

Top module: `conv_pwm`

## Requirements
- R1: While `rst_n` is low, every drive output is 0 (positive polarity applied, inactive), and the slot counter starts from slot 0 when reset is released.
- R2: The slot counter advances by one (modulo 16) on each clock with `tick` high and holds otherwise, so a frame lasts 16 ticks.
- R3: With a channel enabled and running, its output is active exactly in the slots whose number is below the applied duty code, starting at slot 0 of every frame.
- R4: The duty code is 5 bits wide. Code 0 is applied as 1, and codes 16 to 31 are applied as 15.
- R5: A duty, polarity or enable-on change becomes visible only from the frame that starts after the next wrap (a tick while in slot 15).
- R6: A `ch_negative` bit of 1 makes the channel active low and inactive high. A bit of 0 makes it active high and inactive low.
- R7: Lowering a channel's enable forces its output to the inactive level of its applied polarity at once. Raising it resumes pulses from the next frame.
- R8: A feedback level high before clock edge k forces the output inactive from just after edge k+1 (two synchroniser stages). The output stays inactive until the frame wraps, even if feedback falls earlier.
- R9: The two channels are independent: the configuration or feedback of one never changes the other's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slot strobe, 16 per frame |
| ch_enable | input | 2 | Per-channel enable |
| ch_negative | input | 2 | Per-channel polarity, 1 = active low |
| ch_duty | input | 10 | Two 5-bit duty codes, channel 0 in bits 4:0 |
| feedback | input | 2 | Per-channel asynchronous feedback, 1 = suppress |
| drive | output | 2 | Converter switch drive outputs |

## Verification
The slot counter and the applied configuration are registers, so the effect of a wrap tick is seen after the next clock edge. The drive output is combinational from those registers and from the enable, so a disable is seen in the same cycle. Feedback reaches the output one edge later than a synchronised level would, because of its two stages. The bench changes inputs 1 ns after a rising edge and compares every output at the falling edge against a cycle model that follows these latencies. It also counts active cycles over whole frames and checks each count against the clamped duty times the tick spacing.

// File: rtl/conv_pwm.sv
module conv_pwm #(
  parameter int CHANNELS  = 2,
  parameter int SLOT_BITS = 4,
  parameter int DUTY_W    = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic [CHANNELS-1:0]        ch_enable,
  input  logic [CHANNELS-1:0]        ch_negative,
  input  logic [CHANNELS*DUTY_W-1:0] ch_duty,
  input  logic [CHANNELS-1:0]        feedback,
  output logic [CHANNELS-1:0]        drive
);
  localparam int SLOTS = 1 << SLOT_BITS;
  localparam logic [SLOT_BITS-1:0] LAST_SLOT = SLOT_BITS'(SLOTS - 1);
  localparam logic [DUTY_W-1:0]    CODE_MAX  = DUTY_W'(SLOTS - 1);

  logic [SLOT_BITS-1:0]          slot;
  logic                          wrap;
  logic [CHANNELS-1:0]           sync1, sync2, run_q, neg_q, blk_q;
  logic [CHANNELS*SLOT_BITS-1:0] duty_q;

  assign wrap = tick && (slot == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot  <= '0;
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      if (tick) slot <= slot + 1'b1;
      sync1 <= feedback;
      sync2 <= sync1;
    end
  end

  for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
    logic [DUTY_W-1:0]    code;
    logic [SLOT_BITS-1:0] legal;
    logic [SLOT_BITS-1:0] cur;

    assign code  = ch_duty[i*DUTY_W +: DUTY_W];
    assign legal = (code == '0)      ? SLOT_BITS'(1) :
                   (code > CODE_MAX) ? LAST_SLOT     : code[SLOT_BITS-1:0];
    assign cur   = duty_q[i*SLOT_BITS +: SLOT_BITS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        duty_q[i*SLOT_BITS +: SLOT_BITS] <= SLOT_BITS'(1);
        run_q[i] <= 1'b0;
        neg_q[i] <= 1'b0;
        blk_q[i] <= 1'b0;
      end else begin
        if (wrap) begin
          duty_q[i*SLOT_BITS +: SLOT_BITS] <= legal;
          run_q[i] <= ch_enable[i];
          neg_q[i] <= ch_negative[i];
          blk_q[i] <= 1'b0;
        end else if (sync2[i]) begin
          blk_q[i] <= 1'b1;
        end
      end
    end

    assign drive[i] = (ch_enable[i] && run_q[i] && (slot < cur) &&
                       !blk_q[i] && !sync2[i]) ^ neg_q[i];
  end
endmodule

module conv_pwm_checks #(
  parameter int CHANNELS  = 2,
  parameter int SLOT_BITS = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tick,
  input logic [CHANNELS-1:0]           ch_enable,
  input logic [CHANNELS-1:0]           drive,
  input logic [SLOT_BITS-1:0]          slot,
  input logic [CHANNELS*SLOT_BITS-1:0] duty_q,
  input logic [CHANNELS-1:0]           neg_q,
  input logic [CHANNELS-1:0]           blk_q,
  input logic [CHANNELS-1:0]           sync2
);
  localparam logic [SLOT_BITS-1:0] LAST = SLOT_BITS'((1 << SLOT_BITS) - 1);

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(slot)); // R2
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> slot == SLOT_BITS'($past(slot) + 1'b1)); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && slot == LAST) |=> $stable(duty_q) && $stable(neg_q)); // R5

  for (genvar i = 0; i < CHANNELS; i++) begin : g_a
    AST_DUTY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      duty_q[i*SLOT_BITS +: SLOT_BITS] != '0); // R4
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_enable[i] |-> drive[i] == neg_q[i]); // R7
    AST_FB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      blk_q[i] |-> drive[i] == neg_q[i]); // R8
    AST_FB_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (sync2[i] && !(tick && slot == LAST)) |=> blk_q[i]); // R8
  end
endmodule

bind conv_pwm conv_pwm_checks #(.CHANNELS(CHANNELS), .SLOT_BITS(SLOT_BITS)) u_checks (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ch_enable(ch_enable), .drive(drive),
  .slot(slot), .duty_q(duty_q), .neg_q(neg_q), .blk_q(blk_q), .sync2(sync2));

// File: tb/conv_pwm_test.sv
module conv_pwm_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] ch_enable = '0, ch_negative = '0, feedback = '0;
  logic [9:0] ch_duty = '0;
  logic [1:0] drive;

  int    checks = 0, errors = 0;
  int    tick_div = 1;
  string tag = "R1";

  always #4 clk = ~clk;

  conv_pwm uut (.clk(clk), .rst_n(rst_n), .tick(tick), .ch_enable(ch_enable),
    .ch_negative(ch_negative), .ch_duty(ch_duty), .feedback(feedback), .drive(drive));

  function automatic int clampd(int d);
    return (d == 0) ? 1 : ((d > 15) ? 15 : d);
  endfunction

  task automatic chk(string t, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: drive=%b expected=%b at %0t", t, act, exp, $time);
    end
  endtask

  int tdiv_cnt = 0;
  always @(posedge clk) begin
    #1;
    tdiv_cnt = (tdiv_cnt + 1 >= tick_div) ? 0 : tdiv_cnt + 1;
    tick = (tdiv_cnt == 0);
  end

  int         m_slot;
  int         m_duty [2];
  logic [1:0] m_run, m_neg, m_blk, m_f1, m_f2;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_slot = 0; m_run = '0; m_neg = '0; m_blk = '0; m_f1 = '0; m_f2 = '0;
      m_duty[0] = 1; m_duty[1] = 1;
    end else begin
      logic wrap_now;
      wrap_now = tick && (m_slot == 15);
      for (int c = 0; c < 2; c++) begin
        if (wrap_now) begin
          m_duty[c] = clampd(int'(ch_duty[c*5 +: 5]));
          m_run[c] = ch_enable[c]; m_neg[c] = ch_negative[c]; m_blk[c] = 1'b0;
        end else if (m_f2[c]) m_blk[c] = 1'b1;
      end
      m_f2 = m_f1; m_f1 = feedback;
      if (tick) m_slot = (m_slot + 1) % 16;
    end
  end

  always @(negedge clk) begin
    logic [1:0] e;
    if (!rst_n) chk("R1", drive, 2'b00);
    else begin
      for (int c = 0; c < 2; c++)
        e[c] = (ch_enable[c] && m_run[c] && (m_slot < m_duty[c]) && !m_blk[c] && !m_f2[c]) ^ m_neg[c];
      chk(tag, drive, e);
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic count_active(int c, logic pol, int n, int exp, string t);
    int act = 0;
    repeat (n) begin @(negedge clk); if (drive[c] ^ pol) act++; end
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: ch%0d active=%0d expected=%0d", t, c, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tag = "R1";
    step(5);
    rst_n = 1'b1;
    step(3);
    tag = "R3";
    ch_enable = 2'b11; ch_duty = {5'd9, 5'd4};
    step(40);
    count_active(0, 1'b0, 16, 4, "R3");
    count_active(1, 1'b0, 16, 9, "R9");
    for (int d = 0; d < 32; d++) begin
      for (int p = 0; p < 2; p++) begin
        tag = "R4";
        ch_duty = {5'(31 - d), 5'(d)};
        ch_negative = {1'(p ^ 1), 1'(p)};
        step(33);
        count_active(0, 1'(p), 16, clampd(d), "R4");
        count_active(1, 1'(p ^ 1), 16, clampd(31 - d), "R6");
      end
    end
    tag = "R2";
    ch_negative = 2'b00; ch_duty = {5'd3, 5'd5};
    tick_div = 3;
    step(110);
    count_active(0, 1'b0, 48, 15, "R2");
    count_active(1, 1'b0, 48, 9, "R2");
    tick_div = 1;
    step(20);
    tag = "R5";
    repeat (6) begin
      ch_duty = {5'd2, 5'd12}; ch_negative = 2'b01; step(7);
      ch_duty = {5'd14, 5'd3}; ch_negative = 2'b10; step(11);
    end
    step(20);
    tag = "R7";
    ch_negative = 2'b00; ch_duty = {5'd15, 5'd15};
    step(34);
    ch_enable = 2'b10; step(1);
    @(negedge clk); chk("R7", {1'b0, drive[0]}, 2'b00);
    step(40);
    count_active(0, 1'b0, 16, 0, "R7");
    ch_enable = 2'b11; step(40);
    count_active(0, 1'b0, 16, 15, "R7");
    tag = "R8";
    ch_duty = {5'd12, 5'd12};
    step(20);
    repeat (4) begin
      step(3); feedback = 2'b01; step(1); feedback = 2'b00; step(12);
    end
    feedback = 2'b10; step(2); feedback = 2'b00;
    step(30);
    count_active(1, 1'b0, 16, 12, "R8");
    step(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule